// File: doc/BRIEF.md
# Multicycle Accumulator Processor Controller

This block is a small stored-program processor built around one accumulator. Instructions and operands live in the same external synchronous memory and reach the processor over one address/data port. Every transfer passes through an address holding register and a data holding register. A state machine moves each instruction through three phases: fetch, decode and a multi-state execute. Each state does one register-to-register step.

The memory sits outside the block. A read strobe returns the addressed word on the read data input one clock later. A write strobe stores the write data at the driven address on the same clock edge. The environment loads a program at address 0 and releases reset. It then waits for the halted output and inspects the accumulator and memory. A phase indicator shows which part of the instruction cycle is running.

Top module: `acc_cpu`

## Requirements
- R1: The read strobe and the write strobe are never high in the same cycle. No strobe is raised during the decode phase.
- R2: A fetch works as follows. The program counter is copied to the address register. A one-cycle read strobe is raised while the address output equals the program counter. The word returned one clock later goes to the data register and then to the instruction register. The program counter rises by one during the fetch, and the first fetch after reset reads address 0.
- R3: An instruction word holds the opcode in bits 15:12 and a 12-bit address operand in bits 11:0. The opcode values are: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 and, 6 or, 7 jump, 8 jump-if-zero.
- R4: Load reads the word at the operand address into the accumulator.
- R5: Add and subtract combine the accumulator with the word at the operand address, modulo 2^16. And/or do the same bitwise. The result replaces the accumulator.
- R6: Store drives the operand address and the accumulator value with a write strobe that lasts exactly one cycle. No other address is written.
- R7: Jump loads the program counter from the operand, so the next fetch comes from there.
- R8: Jump-if-zero loads the program counter from the operand only when the accumulator is zero. Otherwise execution continues at the next sequential word.
- R9: Halt raises the halted output and sets the phase output to 3. No further strobes occur, and the program counter stays unchanged until reset.
- R10: Reset is active-low and asynchronous. It clears the program counter, the accumulator and the holding registers, sets the phase output to 0 (fetch), and keeps halted low. The phase codes are: 0 fetch, 1 decode, 2 execute, 3 halted.
- R11: Opcodes 9 to 15 leave the accumulator and memory untouched and do not change the program counter beyond the normal fetch increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Shared memory address, driven by the address register |
| mem_wdata_o | output | 16 | Write data, driven by the data register |
| mem_rdata_i | input | 16 | Read data, valid one clock after the read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| phase_o | output | 2 | Instruction cycle phase: 0 fetch, 1 decode, 2 execute, 3 halted |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
The bench sweeps every ALU and load opcode over a grid of operand pairs that includes zero, all-ones and the sign bit. A datapath that mishandles carry or borrow wrap-around, or that captures read data one cycle early or late, leaves a wrong accumulator or stored word. Jump-if-zero runs against zero and several non-zero accumulators. A machine that tests the wrong condition, or tests only some bits, ends on the wrong load and at the wrong final program counter. Undefined opcodes, the halt state held for many cycles, and a reset dropped in the middle of an instruction are all exercised. These expose a design that writes spuriously, keeps strobing after halting, or clears its registers only on a clock edge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_JMP   = 4'd7,
    OP_JZ    = 4'd8
  } opcode_e;

  typedef enum logic [3:0] {
    S_F_ADDR,
    S_F_READ,
    S_F_CAPT,
    S_F_LOAD,
    S_DEC,
    S_X_ADDR,
    S_X_READ,
    S_X_CAPT,
    S_X_ALU,
    S_X_WRITE,
    S_X_BR,
    S_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR
  } alu_op_e;

  localparam logic [1:0] PH_FETCH  = 2'd0;
  localparam logic [1:0] PH_DECODE = 2'd1;
  localparam logic [1:0] PH_EXEC   = 2'd2;
  localparam logic [1:0] PH_HALT   = 2'd3;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_opnd;
    logic    pc_inc;
    logic    pc_load;
    logic    mdr_from_mem;
    logic    mdr_from_acc;
    logic    cir_load;
    logic    acc_load;
    logic    mem_rd;
    logic    mem_wr;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = acc_i + opnd_i;
      ALU_SUB: res_o = acc_i - opnd_i;
      ALU_AND: res_o = acc_i & opnd_i;
      ALU_OR:  res_o = acc_i | opnd_i;
      default: res_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            acc_zero_i,
  output state_e          state_o,
  output logic [1:0]      phase_o,
  output ctrl_t           ctrl_o,
  output logic            halted_o
);

  state_e state_q, state_d;
  logic   is_mem_op, is_branch, is_store;

  always_comb begin
    is_mem_op = 1'b0;
    is_branch = 1'b0;
    is_store  = 1'b0;
    case (opcode_i)
      OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR: is_mem_op = 1'b1;
      OP_STORE: begin
        is_mem_op = 1'b1;
        is_store  = 1'b1;
      end
      OP_JMP, OP_JZ: is_branch = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_F_ADDR:  state_d = S_F_READ;
      S_F_READ:  state_d = S_F_CAPT;
      S_F_CAPT:  state_d = S_F_LOAD;
      S_F_LOAD:  state_d = S_DEC;
      S_DEC: begin
        if (opcode_i == OP_HALT) state_d = S_HALT;
        else if (is_mem_op)      state_d = S_X_ADDR;
        else if (is_branch)      state_d = S_X_BR;
        else                     state_d = S_F_ADDR;
      end
      S_X_ADDR:  state_d = is_store ? S_X_WRITE : S_X_READ;
      S_X_READ:  state_d = S_X_CAPT;
      S_X_CAPT:  state_d = S_X_ALU;
      S_X_ALU:   state_d = S_F_ADDR;
      S_X_WRITE: state_d = S_F_ADDR;
      S_X_BR:    state_d = S_F_ADDR;
      S_HALT:    state_d = S_HALT;
      default:   state_d = S_F_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o = '0;
    case (opcode_i)
      OP_ADD:  ctrl_o.alu_op = ALU_ADD;
      OP_SUB:  ctrl_o.alu_op = ALU_SUB;
      OP_AND:  ctrl_o.alu_op = ALU_AND;
      OP_OR:   ctrl_o.alu_op = ALU_OR;
      default: ctrl_o.alu_op = ALU_PASS;
    endcase
    case (state_q)
      S_F_ADDR:  ctrl_o.mar_from_pc = 1'b1;
      S_F_READ: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.pc_inc = 1'b1;
      end
      S_F_CAPT:  ctrl_o.mdr_from_mem = 1'b1;
      S_F_LOAD:  ctrl_o.cir_load = 1'b1;
      S_X_ADDR: begin
        ctrl_o.mar_from_opnd = 1'b1;
        ctrl_o.mdr_from_acc  = is_store;
      end
      S_X_READ:  ctrl_o.mem_rd = 1'b1;
      S_X_CAPT:  ctrl_o.mdr_from_mem = 1'b1;
      S_X_ALU:   ctrl_o.acc_load = 1'b1;
      S_X_WRITE: ctrl_o.mem_wr = 1'b1;
      S_X_BR:    ctrl_o.pc_load = (opcode_i == OP_JMP) || acc_zero_i;
      default: ;
    endcase
  end

  always_comb begin
    case (state_q)
      S_F_ADDR, S_F_READ, S_F_CAPT, S_F_LOAD: phase_o = PH_FETCH;
      S_DEC:   phase_o = PH_DECODE;
      S_HALT:  phase_o = PH_HALT;
      default: phase_o = PH_EXEC;
    endcase
  end

  assign halted_o = (state_q == S_HALT);
  assign state_o  = state_q;

  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o.mem_rd && ctrl_o.mem_wr));

  assert_quiet_decode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_DECODE) |-> !(ctrl_o.mem_rd || ctrl_o.mem_wr));

  assert_write_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.mem_wr |=> !ctrl_o.mem_wr);

  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !ctrl_o.mem_rd && !ctrl_o.mem_wr && !ctrl_o.pc_inc);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [1:0]        phase_o,
  output logic              halted_o
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q, alu_res;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] operand;
  ctrl_t             ctrl;
  state_e            state;

  assign opcode  = cir_q[DATA_W-1 -: OP_W];
  assign operand = cir_q[ADDR_W-1:0];

  acc_cpu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opcode_i   (opcode),
    .acc_zero_i (acc_q == '0),
    .state_o    (state),
    .phase_o    (phase_o),
    .ctrl_o     (ctrl),
    .halted_o   (halted_o)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (ctrl.alu_op),
    .acc_i  (acc_q),
    .opnd_i (mdr_q),
    .res_o  (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      if (ctrl.pc_load)      pc_q <= operand;
      else if (ctrl.pc_inc)  pc_q <= pc_q + 1'b1;
      if (ctrl.mar_from_pc)        mar_q <= pc_q;
      else if (ctrl.mar_from_opnd) mar_q <= operand;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
    end else begin
      if (ctrl.mdr_from_mem)      mdr_q <= mem_rdata_i;
      else if (ctrl.mdr_from_acc) mdr_q <= acc_q;
      if (ctrl.cir_load) cir_q <= mdr_q;
      if (ctrl.acc_load) acc_q <= alu_res;
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_rd_o    = ctrl.mem_rd;
  assign mem_wr_o    = ctrl.mem_wr;
  assign pc_o        = pc_q;
  assign acc_o       = acc_q;

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_F_READ) |-> (mem_addr_o == pc_q) && mem_rd_o);

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_F_READ) |=> pc_q == $past(pc_q) + 1'b1);

  assert_cir_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_F_LOAD) |=> cir_q == $past(mdr_q));

  assert_store_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_wdata_o == acc_q) && (mem_addr_o == operand));

  assert_jz_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_X_BR && opcode == OP_JZ && acc_q != '0) |=> $stable(pc_q));

  assert_jmp_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_X_BR && opcode == OP_JMP) |=> pc_q == $past(operand));

  assert_acc_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != S_X_ALU) |=> $stable(acc_q));

endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, pc;
  logic [15:0] mem_wdata, acc;
  logic [15:0] rdata_q = '0;
  logic        mem_rd, mem_wr, halted;
  logic [1:0]  phase;

  logic [15:0] mem [0:255];

  int n_checks = 0;
  int n_fail   = 0;

  int n_fetch, n_dread, n_wr, first_addr;
  int err_both, err_dec, err_halt, err_wlen, err_faddr, err_hphase;
  logic wr_prev;

  always #4 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (rdata_q),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .pc_o        (pc),
    .acc_o       (acc),
    .phase_o     (phase),
    .halted_o    (halted)
  );

  always @(posedge clk) begin
    if (mem_rd) rdata_q <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) err_both++;
      if (phase == 2'd1 && (mem_rd || mem_wr)) err_dec++;
      if (halted && (mem_rd || mem_wr)) err_halt++;
      if (halted && phase != 2'd3) err_hphase++;
      if (mem_wr && wr_prev) err_wlen++;
      if (mem_rd && phase == 2'd0) begin
        if (n_fetch == 0) first_addr = int'(mem_addr);
        if (mem_addr != pc) err_faddr++;
        n_fetch++;
      end
      if (mem_rd && phase == 2'd2) n_dread++;
      if (mem_wr) n_wr++;
      wr_prev = mem_wr;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_fetch = 0; n_dread = 0; n_wr = 0; first_addr = -1;
    err_both = 0; err_dec = 0; err_halt = 0; err_wlen = 0;
    err_faddr = 0; err_hphase = 0; wr_prev = 1'b0;
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  function automatic logic [15:0] ins(int op, int opnd);
    return {4'(op), 12'(opnd)};
  endfunction

  function automatic logic [15:0] val(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h0001;
      default: return 16'(k * 16'h3A5B) ^ 16'h1C3D;
    endcase
  endfunction

  task automatic start();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    clr_mon();
    rst_n = 1'b1;
  endtask

  task automatic run_prog(output bit done);
    start();
    done = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (halted) begin
        done = 1'b1;
        break;
      end
    end
  endtask

  task automatic chk_bus(string tag);
    chk("R1", {tag, " rd/wr overlap"}, err_both, 0);
    chk("R1", {tag, " strobe in decode"}, err_dec, 0);
    chk("R2", {tag, " fetch address vs pc"}, err_faddr, 0);
    chk("R9", {tag, " strobe while halted"}, err_halt, 0);
    chk("R6", {tag, " write pulse length"}, err_wlen, 0);
  endtask

  initial begin
    bit done;
    logic [15:0] a, b, exp_v;
    int ops [5] = '{1, 3, 4, 5, 6};

    // R10: reset state
    clr_mem();
    clr_mon();
    repeat (3) @(negedge clk);
    chk("R10", "pc in reset", pc, 0);
    chk("R10", "acc in reset", acc, 0);
    chk("R10", "phase in reset", phase, 0);
    chk("R10", "halted in reset", halted, 0);
    chk("R10", "strobes in reset", {mem_rd, mem_wr}, 0);

    // R9: halt alone
    mem[0] = ins(0, 0);
    run_prog(done);
    chk("R9", "halt reached", done, 1);
    chk("R9", "phase halted", phase, 3);
    chk("R2", "first fetch address", first_addr, 0);
    chk("R9", "pc after halt", pc, 1);
    chk("R9", "fetch count", n_fetch, 1);
    repeat (30) @(negedge clk);
    chk("R9", "pc held", pc, 1);
    chk("R9", "still halted", halted, 1);
    chk("R9", "halted phase", err_hphase, 0);
    chk_bus("halt");

    // R4 R5 R6: load / alu / store sweep
    foreach (ops[oi]) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          a = val(i);
          b = val(j);
          case (ops[oi])
            1: exp_v = b;
            3: exp_v = a + b;
            4: exp_v = a - b;
            5: exp_v = a & b;
            default: exp_v = a | b;
          endcase
          clr_mem();
          mem[0] = ins(1, 8'h80);
          mem[1] = ins(ops[oi], 8'h81);
          mem[2] = ins(2, 8'h82);
          mem[3] = ins(0, 0);
          mem[8'h80] = a;
          mem[8'h81] = b;
          run_prog(done);
          chk("R9", "alu prog halted", done, 1);
          chk(ops[oi] == 1 ? "R4" : "R5", $sformatf("acc op%0d", ops[oi]), acc, exp_v);
          chk("R6", "stored word", mem[8'h82], exp_v);
          chk("R6", "source untouched", mem[8'h80], a);
          chk("R6", "write count", n_wr, 1);
          chk("R2", "fetch count", n_fetch, 4);
          chk("R3", "data read count", n_dread, 2);
          chk("R2", "final pc", pc, 4);
        end
      end
    end
    chk_bus("alu");

    // R7: unconditional jump
    clr_mem();
    mem[0] = ins(7, 5);
    mem[1] = ins(1, 8'h80);
    mem[2] = ins(0, 0);
    mem[5] = ins(1, 8'h81);
    mem[6] = ins(0, 0);
    mem[8'h80] = 16'h0111;
    mem[8'h81] = 16'h0BEE;
    run_prog(done);
    chk("R7", "jump halted", done, 1);
    chk("R7", "acc after jump", acc, 16'h0BEE);
    chk("R7", "pc after jump", pc, 7);
    chk("R7", "fetch count", n_fetch, 3);
    chk_bus("jmp");

    // R8: conditional branch against several accumulator values
    for (int k = 0; k < 8; k++) begin
      clr_mem();
      mem[0] = ins(1, 8'h80);
      mem[1] = ins(8, 4);
      mem[2] = ins(1, 8'h81);
      mem[3] = ins(0, 0);
      mem[4] = ins(1, 8'h82);
      mem[5] = ins(0, 0);
      mem[8'h80] = val(k);
      mem[8'h81] = 16'hA5A5;
      mem[8'h82] = 16'h5A5A;
      run_prog(done);
      chk("R8", "jz halted", done, 1);
      chk("R8", $sformatf("jz acc k=%0d", k), acc, val(k) == 0 ? 16'h5A5A : 16'hA5A5);
      chk("R8", $sformatf("jz pc k=%0d", k), pc, val(k) == 0 ? 6 : 4);
      chk("R8", "jz fetch count", n_fetch, 4);
    end
    chk_bus("jz");

    // R11: undefined opcodes
    for (int op = 9; op < 16; op++) begin
      clr_mem();
      mem[0] = ins(1, 8'h80);
      mem[1] = ins(op, 8'h81);
      mem[2] = ins(0, 0);
      mem[8'h80] = 16'h1234;
      mem[8'h81] = 16'h7777;
      run_prog(done);
      chk("R11", $sformatf("op%0d halted", op), done, 1);
      chk("R11", $sformatf("op%0d acc", op), acc, 16'h1234);
      chk("R11", $sformatf("op%0d pc", op), pc, 3);
      chk("R11", $sformatf("op%0d writes", op), n_wr, 0);
      chk("R11", $sformatf("op%0d operand word", op), mem[8'h81], 16'h7777);
    end
    chk_bus("undef");

    // R10: asynchronous reset in the middle of an instruction
    clr_mem();
    mem[0] = ins(1, 8'h80);
    mem[1] = ins(0, 0);
    mem[8'h80] = 16'hCAFE;
    start();
    repeat (7) @(negedge clk);
    chk("R10", "pc moved before reset", pc, 1);
    rst_n = 1'b0;
    #1;
    chk("R10", "async pc clear", pc, 0);
    chk("R10", "async phase", phase, 0);
    chk("R10", "async strobes", {mem_rd, mem_wr}, 0);
    run_prog(done);
    chk("R10", "rerun acc", acc, 16'hCAFE);
    chk("R10", "rerun pc", pc, 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule